// File: doc/BRIEF.md
# Slave-Mode Bus Access Gate

This block sits on a processor board that can also serve as a bus slave. In that role the board's local 64 KB RAM appears in the bus master's 24-bit address space, at one of 256 segments of 64 KB each. The block compares the top eight address bits with a board segment setting and reports a continuous board-select whenever they agree. It does not wait for a cycle strobe.

When a bus memory cycle that targets the board begins, the block stretches that cycle. A wait counter is loaded from a 3-bit setting and counted down on rising edges of the bus clock. While the counter is non-zero, the block asks the open-drain ready line to be pulled low, so the local RAM has time to settle. In master mode the whole block is inert. In slave mode the bus slave-clear line becomes a local reset for the rest of the board.

Top module: `slave_bus_gate`

## Requirements
- R1: In slave mode (`slave_mode`=1), `brd_sel` is 1 in the same cycle exactly when `bus_addr[23:16]` equals `seg_base`.
- R2: `brd_sel` follows the address alone. It needs no cycle strobe and no read or write qualifier.
- R3: A selected memory cycle begins when, at a rising edge, `cyc_start`=1, `mem_rd` or `mem_wr` is 1, and the address matches. With a wait setting N of 1 to 5, `rdy_pull_low` is then 1 for exactly N clock periods following that edge, and 0 afterwards.
- R4: A wait setting of 0 produces no `rdy_pull_low` at all.
- R5: Wait settings of 6 and 7 behave as 5.
- R6: No wait is produced for a `cyc_start` whose address does not match, or that has neither `mem_rd` nor `mem_wr`.
- R7: A selected cycle start that arrives while `rdy_pull_low` is 1 is ignored, and the running count continues unchanged.
- R8: In master mode (`slave_mode`=0), `brd_sel`, `rdy_pull_low` and `local_rst` are all 0. Any count in progress is abandoned.
- R9: In slave mode, `slv_clr_n`=0 sets `local_rst` to 1 in the same cycle and abandons any count in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bus_clk | input | 1 | Bus clock; the wait counter counts its rising edges |
| bus_addr | input | 24 | Bus address |
| cyc_start | input | 1 | One-clock marker of the first clock of a bus cycle |
| mem_rd | input | 1 | Cycle is a memory read |
| mem_wr | input | 1 | Cycle is a memory write |
| seg_base | input | 8 | Board segment setting, compared with address bits 23..16 |
| wait_sel | input | 3 | Requested wait length in bus clocks (values above 5 are treated as 5) |
| slave_mode | input | 1 | 1 = slave mode, 0 = master mode (block disabled) |
| slv_clr_n | input | 1 | Bus slave-clear, active low |
| brd_sel | output | 1 | Board selected by the current address |
| rdy_pull_low | output | 1 | Enable of the open-drain ready driver; 1 pulls ready low |
| local_rst | output | 1 | Local reset, active high |

## Verification
The assertions assume two things about the inputs. First, the environment starts in master mode or with slave-clear asserted for at least one clock edge, because this is the only way the counter is cleared. Second, every input changes only away from the rising edge of the bus clock. The stimulus drives all inputs on the falling edge and opens with several master-mode clocks. The bounded-wait check relies on `cyc_start` being sampled once per edge. The bench therefore treats a start held high for several clocks as several starts, and the reference model does the same.

// File: rtl/sbg_pkg.sv
package sbg_pkg;

  // Clamp a requested wait length to the supported maximum.
  function automatic int sat_wait(input int req, input int lim);
    return (req > lim) ? lim : req;
  endfunction

  // Board segment comparison: upper address field against the base setting.
  function automatic logic seg_hit(input logic [31:0] addr_hi, input logic [31:0] base);
    return addr_hi == base;
  endfunction

endpackage

// File: rtl/sbg_addr_cmp.sv
module sbg_addr_cmp #(
  parameter int ADDR_W = 24,
  parameter int SEG_W  = 8
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [SEG_W-1:0]  base,
  input  logic              en,
  output logic              hit
);
  import sbg_pkg::*;

  logic [SEG_W-1:0] field;

  assign field = addr[ADDR_W-1 -: SEG_W];
  assign hit   = en && seg_hit(32'(field), 32'(base));

endmodule

// File: rtl/sbg_wait_timer.sv
module sbg_wait_timer #(
  parameter int REQ_W    = 3,
  parameter int MAX_WAIT = 5
) (
  input  logic             clk,
  input  logic             abort,
  input  logic             start,
  input  logic [REQ_W-1:0] req,
  output logic             busy,
  output logic             load
);
  import sbg_pkg::*;

  localparam int CW = (MAX_WAIT < 2) ? 1 : $clog2(MAX_WAIT + 1);

  logic [CW-1:0] cnt;
  logic [CW-1:0] len;

  assign len  = CW'(sat_wait(int'(req), MAX_WAIT));
  assign busy = (cnt != '0);
  assign load = start && !busy;

  always_ff @(posedge clk) begin
    if (abort)
      cnt <= '0;
    else if (busy)
      cnt <= cnt - 1'b1;
    else if (start)
      cnt <= len;
  end

endmodule

// File: rtl/sbg_clr_gen.sv
module sbg_clr_gen (
  input  logic slave_en,
  input  logic clr_n,
  output logic local_rst,
  output logic abort
);

  assign local_rst = slave_en && !clr_n;
  assign abort     = !slave_en || !clr_n;

endmodule

// File: rtl/slave_bus_gate.sv
module slave_bus_gate #(
  parameter int ADDR_W   = 24,
  parameter int SEG_W    = 8,
  parameter int REQ_W    = 3,
  parameter int MAX_WAIT = 5
) (
  input  logic              bus_clk,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              cyc_start,
  input  logic              mem_rd,
  input  logic              mem_wr,
  input  logic [SEG_W-1:0]  seg_base,
  input  logic [REQ_W-1:0]  wait_sel,
  input  logic              slave_mode,
  input  logic              slv_clr_n,
  output logic              brd_sel,
  output logic              rdy_pull_low,
  output logic              local_rst
);

  // Named internal events, visible to the bound checker.
  logic hit;
  logic mem_cyc;
  logic start_evt;
  logic abort;
  logic busy;
  logic load;

  sbg_addr_cmp #(.ADDR_W(ADDR_W), .SEG_W(SEG_W)) u_cmp (
    .addr (bus_addr),
    .base (seg_base),
    .en   (slave_mode),
    .hit  (hit)
  );

  sbg_clr_gen u_clr (
    .slave_en  (slave_mode),
    .clr_n     (slv_clr_n),
    .local_rst (local_rst),
    .abort     (abort)
  );

  assign mem_cyc   = mem_rd || mem_wr;
  assign start_evt = cyc_start && mem_cyc && hit;

  sbg_wait_timer #(.REQ_W(REQ_W), .MAX_WAIT(MAX_WAIT)) u_tmr (
    .clk   (bus_clk),
    .abort (abort),
    .start (start_evt),
    .req   (wait_sel),
    .busy  (busy),
    .load  (load)
  );

  assign brd_sel      = hit;
  assign rdy_pull_low = slave_mode && busy;

endmodule

// File: rtl/sbg_checker.sv
module sbg_checker #(
  parameter int REQ_W    = 3,
  parameter int MAX_WAIT = 5
) (
  input logic             clk,
  input logic             slave_mode,
  input logic             slv_clr_n,
  input logic             brd_sel,
  input logic             rdy_pull_low,
  input logic             local_rst,
  input logic             start_evt,
  input logic [REQ_W-1:0] wait_sel
);

  logic clr;
  int   low_run;

  assign clr = !slave_mode || !slv_clr_n;

  always_ff @(posedge clk) begin
    if (clr)               low_run <= 0;
    else if (rdy_pull_low) low_run <= low_run + 1;
    else                   low_run <= 0;
  end

  // R3: a selected start with a non-zero setting pulls ready low next cycle
  p_load_r3: assert property (@(posedge clk) disable iff (clr)
    (start_evt && !rdy_pull_low && wait_sel != '0) |=> rdy_pull_low);

  // R4: a zero setting produces no wait
  p_zero_r4: assert property (@(posedge clk) disable iff (clr)
    (start_evt && !rdy_pull_low && wait_sel == '0) |=> !rdy_pull_low);

  // R5: no wait lasts longer than the maximum
  p_bound_r5: assert property (@(posedge clk) disable iff (clr)
    low_run <= MAX_WAIT);

  // R8: master mode leaves every output quiet
  p_master_r8: assert property (@(posedge clk)
    !slave_mode |-> (!brd_sel && !rdy_pull_low && !local_rst));

  // R9: slave-clear in slave mode gives a local reset
  p_lrst_r9: assert property (@(posedge clk)
    (slave_mode && !slv_clr_n) |-> local_rst);

endmodule

bind slave_bus_gate sbg_checker #(.REQ_W(REQ_W), .MAX_WAIT(MAX_WAIT)) u_chk (
  .clk          (bus_clk),
  .slave_mode   (slave_mode),
  .slv_clr_n    (slv_clr_n),
  .brd_sel      (brd_sel),
  .rdy_pull_low (rdy_pull_low),
  .local_rst    (local_rst),
  .start_evt    (start_evt),
  .wait_sel     (wait_sel)
);

// File: tb/sim_slave_bus_gate.sv
`timescale 1ns/1ps
module sim_slave_bus_gate;

  logic        clk = 1'b0;
  logic [23:0] addr = '0;
  logic        cs = 1'b0, rd = 1'b0, wr = 1'b0;
  logic [7:0]  base = 8'h5A;
  logic [2:0]  ws = '0;
  logic        sm = 1'b0, cn = 1'b1;
  logic        sel, rdy, lrst;

  int n_chk = 0, n_bad = 0;
  int rem = 0;
  bit done = 0;

  always #10 clk = ~clk;

  slave_bus_gate u0 (
    .bus_clk(clk), .bus_addr(addr), .cyc_start(cs), .mem_rd(rd), .mem_wr(wr),
    .seg_base(base), .wait_sel(ws), .slave_mode(sm), .slv_clr_n(cn),
    .brd_sel(sel), .rdy_pull_low(rdy), .local_rst(lrst)
  );

  task automatic cmp(string tag, string what, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%b expected=%b t=%0t", tag, what, act, exp, $time);
    end
  endtask

  // One bus clock: drive at the falling edge, compare, then advance the model.
  task automatic step(string tag, logic [23:0] a, logic c, logic r, logic w,
                      logic [2:0] q, logic s, logic k);
    addr = a; cs = c; rd = r; wr = w; ws = q; sm = s; cn = k;
    #1;
    cmp(tag, "brd_sel", sel, s && (a[23:16] == base));
    cmp(tag, "rdy_pull_low", rdy, s && (rem > 0));
    cmp(tag, "local_rst", lrst, s && !k);
    @(posedge clk);
    if (!s || !k) rem = 0;
    else if (rem > 0) rem--;
    else if (c && (r || w) && a[23:16] == base) rem = (q > 5) ? 5 : int'(q);
    @(negedge clk);
  endtask

  task automatic idle(string tag, int n);
    for (int i = 0; i < n; i++) step(tag, {base, 16'h0000}, 0, 0, 0, 3'd0, 1, 1);
  endtask

  initial begin
    #4_000_000;
    if (!done) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    // R8: master mode at start, quiet outputs even with a matching start
    for (int i = 0; i < 3; i++) step("R8", {base, 16'h1234}, 1, 1, 0, 3'd4, 0, 1);
    // R9: slave-clear gives local reset
    step("R9", 24'h000000, 0, 0, 0, 3'd0, 1, 0);
    step("R9", 24'h000000, 0, 0, 0, 3'd0, 1, 0);
    // R1 / R2: select follows the address with no strobes
    step("R1", {base, 16'hFFFF}, 0, 0, 0, 3'd0, 1, 1);
    step("R1", {8'h5B, 16'h0000}, 0, 0, 0, 3'd0, 1, 1);
    step("R2", {base, 16'h0001}, 0, 1, 1, 3'd3, 1, 1);
    step("R2", {8'h00, 16'h0001}, 0, 1, 0, 3'd3, 1, 1);
    // R3 / R4 / R5: every wait setting
    for (int n = 0; n < 8; n++) begin
      step((n == 0) ? "R4" : (n > 5) ? "R5" : "R3", {base, 16'h0100}, 1, n[0], !n[0], 3'(n), 1, 1);
      idle((n == 0) ? "R4" : (n > 5) ? "R5" : "R3", 7);
    end
    // R6: mismatch and non-memory starts
    step("R6", {8'hA5, 16'h0100}, 1, 1, 0, 3'd5, 1, 1);
    idle("R6", 2);
    step("R6", {base, 16'h0100}, 1, 0, 0, 3'd5, 1, 1);
    idle("R6", 2);
    // R7: new start during a count is ignored
    step("R7", {base, 16'h0200}, 1, 1, 0, 3'd3, 1, 1);
    step("R7", {base, 16'h0200}, 1, 0, 1, 3'd5, 1, 1);
    step("R7", {base, 16'h0200}, 1, 0, 1, 3'd5, 1, 1);
    idle("R7", 7);
    // R8: master mode aborts a count
    step("R8", {base, 16'h0300}, 1, 1, 0, 3'd5, 1, 1);
    step("R8", {base, 16'h0300}, 0, 0, 0, 3'd5, 1, 1);
    step("R8", {base, 16'h0300}, 0, 0, 0, 3'd5, 0, 1);
    idle("R8", 4);
    // R9: slave-clear aborts a count
    step("R9", {base, 16'h0300}, 1, 0, 1, 3'd5, 1, 1);
    step("R9", {base, 16'h0300}, 0, 0, 0, 3'd5, 1, 0);
    idle("R9", 4);
    // Mixed random traffic against the model
    for (int i = 0; i < 600; i++) begin
      logic [7:0] hi;
      hi = ($urandom % 2) ? base : 8'($urandom);
      step("R3", {hi, 16'($urandom)}, ($urandom % 3) == 0, $urandom % 2, $urandom % 2,
           3'($urandom), ($urandom % 20) != 0, ($urandom % 25) != 0);
    end
    base = 8'h00;
    idle("R1", 2);
    step("R1", 24'h00ABCD, 0, 0, 0, 3'd0, 1, 1);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule